// File: doc/BRIEF.md
# Programmable Down-Counter with Square-Wave and One-Shot Output

This block is a down-counter of configurable width (16 bits by default) that advances only on cycles where a prescaled tick input is high. A start strobe loads it from a preload input and sets it running. A stop strobe halts it. A single mode input picks what the waveform output means.

In timer mode the counter reloads itself each time it expires and the waveform output toggles, so the result is a continuous square wave whose half-period is the preload count in ticks. In counter mode the waveform output stays high from the start until the count expires, then drops low. It stays low until a stop strobe arrives, even though the counter keeps decrementing and wrapping underneath.

In both modes, every expiry also raises a terminal-count pulse for one cycle. No mask gates either output, so both go straight to whatever consumes them.

Top module: `ctmr`

## Requirements
- R1: While reset is held and after its release, `wave_out` is 1 and `tc_pulse` is 0 until the first start command.
- R2: After a start with preload N (1..65535), the first terminal count happens on the N-th tick after the start cycle, and a tick in the start cycle itself is not counted. `tc_pulse` is 1 in the cycle that follows the clock edge that sampled that tick.
- R3: A preload of 0 counts as 65536 ticks.
- R4: With `mode` = 1 (timer), the counter reloads the preload at every terminal count and `wave_out` toggles there. Terminal counts therefore come every N ticks and the square wave has a half-period of N ticks, starting high.
- R5: With `mode` = 0 (counter), `wave_out` stays 1 from the start until the terminal count and becomes 0 in the same cycle as that terminal count's `tc_pulse`.
- R6: In counter mode, after the terminal count, `wave_out` stays 0. The counter keeps decrementing through wrap-around, so a further `tc_pulse` appears every 65536 ticks.
- R7: A stop command makes `wave_out` 1 and `tc_pulse` 0 in the next cycle, halts counting, and no terminal count happens until the next start.
- R8: When start and stop are high in the same cycle, stop takes effect and start is ignored.
- R9: A start while already running reloads the preload, makes `wave_out` 1 in the next cycle, and restarts the count from N.
- R10: Ticks while the counter is not running have no effect on either output.
- R11: `tc_pulse` is 1 only in the cycle after a counted tick, for exactly one cycle per terminal count, and is 0 in cycles that follow a cycle with no tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaled source |
| preload | input | CNT_W | Count loaded by a start; 0 means 2^CNT_W |
| mode | input | 1 | 1 = timer (square wave), 0 = counter (one-shot) |
| start | input | 1 | Start strobe: load and run |
| stop | input | 1 | Stop strobe: halt and force output high |
| wave_out | output | 1 | Square wave (timer) or high-until-expiry level (counter) |
| tc_pulse | output | 1 | One-cycle terminal-count event |

## Verification
Some properties are checked on every cycle. The waveform changes only at a terminal count or after a command. In counter mode it holds low until a command arrives. The pulse follows only a counted tick while the block is armed. Both commands force the output high and the pulse low one cycle later.

Only the bench's scenarios can show how many ticks separate a start from the first expiry, and the same holds for the spacing between later expiries. Those scenarios sweep small preloads, tick gaps and both modes, and include the 65536-tick cases for a zero preload and for counter-mode wrap.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_HALT = 2'd2
    } ctmr_cmd_e;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_TIMER = 1'b1
    } ctmr_mode_e;

endpackage

// File: rtl/ctmr_cmd.sv
module ctmr_cmd
    import ctmr_pkg::*;
(
    input  logic      start_i,
    input  logic      stop_i,
    output ctmr_cmd_e cmd_o
);

    // Halt outranks load when both strobes coincide (R8).
    always_comb begin
        if (stop_i) begin
            cmd_o = CMD_HALT;
        end else if (start_i) begin
            cmd_o = CMD_LOAD;
        end else begin
            cmd_o = CMD_NONE;
        end
    end

endmodule

// File: rtl/ctmr_downcnt.sv
module ctmr_downcnt
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctmr_cmd_e        cmd_i,
    input  ctmr_mode_e       mode_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic             run_o,
    output logic             tc_evt_o
);

    localparam logic [CNT_W-1:0] LSB_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO    = '0;

    // rem holds ticks remaining minus one, so a zero preload wraps to all ones (R3).
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] rem;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;
    logic       tc_evt;
    logic [CNT_W-1:0] reload_val;

    assign reload_val = preload_i - LSB_ONE;

    always_comb begin
        cnt_d  = cnt_q;
        tc_evt = cnt_q.run && tick_i && (cmd_i == CMD_NONE) && (cnt_q.rem == ZERO);
        unique case (cmd_i)
            CMD_HALT: begin
                cnt_d.run = 1'b0;
            end
            CMD_LOAD: begin
                cnt_d.run = 1'b1;
                cnt_d.rem = reload_val;
            end
            default: begin
                if (cnt_q.run && tick_i) begin
                    if (tc_evt && (mode_i == MODE_TIMER)) begin
                        cnt_d.rem = reload_val;
                    end else begin
                        cnt_d.rem = cnt_q.rem - LSB_ONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '{run: 1'b0, rem: '0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign run_o    = cnt_q.run;
    assign tc_evt_o = tc_evt;

endmodule

// File: rtl/ctmr_wave.sv
module ctmr_wave
    import ctmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctmr_cmd_e  cmd_i,
    input  ctmr_mode_e mode_i,
    input  logic       tc_evt_i,
    output logic       wave_o,
    output logic       tc_o
);

    typedef struct packed {
        logic wave;
        logic tc;
    } wave_state_t;

    wave_state_t wv_d, wv_q;

    always_comb begin
        wv_d    = wv_q;
        wv_d.tc = tc_evt_i;
        if (cmd_i != CMD_NONE) begin
            wv_d.wave = 1'b1;
        end else if (tc_evt_i) begin
            wv_d.wave = (mode_i == MODE_TIMER) ? ~wv_q.wave : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wv_q <= '{wave: 1'b1, tc: 1'b0};
        end else begin
            wv_q <= wv_d;
        end
    end

    assign wave_o = wv_q.wave;
    assign tc_o   = wv_q.tc;

endmodule

// File: rtl/ctmr.sv
module ctmr
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] preload,
    input  logic             mode,
    input  logic             start,
    input  logic             stop,
    output logic             wave_out,
    output logic             tc_pulse
);

    ctmr_cmd_e  cmd;
    ctmr_mode_e mode_e;
    logic       run;
    logic       tc_evt;

    assign mode_e = ctmr_mode_e'(mode);

    ctmr_cmd u_cmd (
        .start_i (start),
        .stop_i  (stop),
        .cmd_o   (cmd)
    );

    ctmr_downcnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .mode_i    (mode_e),
        .tick_i    (tick),
        .preload_i (preload),
        .run_o     (run),
        .tc_evt_o  (tc_evt)
    );

    ctmr_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .mode_i   (mode_e),
        .tc_evt_i (tc_evt),
        .wave_o   (wave_out),
        .tc_o     (tc_pulse)
    );

    logic unused_run;
    assign unused_run = run;

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] preload,
    input logic             mode,
    input logic             start,
    input logic             stop,
    input logic             wave_out,
    input logic             tc_pulse
);

    // Independent view of whether a start is in force, built from the strobes only.
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (stop) begin
            armed <= 1'b0;
        end else if (start) begin
            armed <= 1'b1;
        end
    end

    logic [CNT_W-1:0] unused_preload;
    assign unused_preload = preload;

    a_r7_stop_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (wave_out && !tc_pulse));

    a_r9_start_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wave_out && !tc_pulse));

    a_r10_no_tc_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(armed));

    a_r11_tc_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> ($past(tick) && !$past(start) && !$past(stop)));

    a_r5_fall_only_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wave_out) |-> tc_pulse);

    a_r6_counter_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_out && !mode && !start && !stop) |=> !wave_out);

    a_r4_timer_toggles_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && $past(mode)) |-> !$stable(wave_out));

    a_r4_change_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wave_out) && !$past(start) && !$past(stop)) |-> tc_pulse);

endmodule

bind ctmr ctmr_checker #(.CNT_W(CNT_W)) u_ctmr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .preload  (preload),
    .mode     (mode),
    .start    (start),
    .stop     (stop),
    .wave_out (wave_out),
    .tc_pulse (tc_pulse)
);

// File: tb/ctmr_bench.sv
module ctmr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int FULL       = 65536;
    localparam int WD_CYCLES  = 180000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] preload = '0;
    logic         mode = 1'b0;
    logic         start = 1'b0;
    logic         stop = 1'b0;
    logic         wave_out;
    logic         tc_pulse;

    int total = 0;
    int bad = 0;
    int k = 0;
    int P = 1;
    bit m_timer = 1'b0;
    logic exp_wave = 1'b1;

    ctmr #(.CNT_W(W)) u_ctmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .preload  (preload),
        .mode     (mode),
        .start    (start),
        .stop     (stop),
        .wave_out (wave_out),
        .tc_pulse (tc_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s k=%0d: actual=%0b expected=%0b", req, what, k, act, exp);
        end
    endtask

    task automatic cyc(logic tk, logic st, logic sp);
        @(negedge clk);
        tick = tk;
        start = st;
        stop = sp;
        @(posedge clk);
        #1;
    endtask

    task automatic do_start(int p, bit timer, logic tk, string req);
        mode = timer;
        preload = p[W-1:0];
        cyc(tk, 1'b1, 1'b0);
        P = (p == 0) ? FULL : p;
        k = 0;
        m_timer = timer;
        exp_wave = 1'b1;
        check(req, "wave after start", wave_out, 1'b1);
        check(req, "tc after start", tc_pulse, 1'b0);
    endtask

    task automatic do_tick(string req);
        logic exp_tc;
        cyc(1'b1, 1'b0, 1'b0);
        k++;
        if (m_timer) begin
            exp_tc   = ((k % P) == 0);
            exp_wave = (((k / P) % 2) == 0);
        end else begin
            exp_tc   = (k >= P) && (((k - P) % FULL) == 0);
            exp_wave = (k < P);
        end
        check(req, "tc", tc_pulse, exp_tc);
        check(req, "wave", wave_out, exp_wave);
    endtask

    task automatic do_idle(string req);
        cyc(1'b0, 1'b0, 1'b0);
        check(req, "tc idle", tc_pulse, 1'b0);
        check(req, "wave idle", wave_out, exp_wave);
    endtask

    task automatic do_stop(string req);
        cyc(1'b0, 1'b0, 1'b1);
        exp_wave = 1'b1;
        check(req, "wave after stop", wave_out, 1'b1);
        check(req, "tc after stop", tc_pulse, 1'b0);
    endtask

    task automatic dead_ticks(int n, string req);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 1'b0);
            check(req, "tc while halted", tc_pulse, 1'b0);
            check(req, "wave while halted", wave_out, 1'b1);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(posedge clk);
        #1;
        check("R1", "wave in reset", wave_out, 1'b1);
        check("R1", "tc in reset", tc_pulse, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "wave after reset", wave_out, 1'b1);
        check("R1", "tc after reset", tc_pulse, 1'b0);
        // R10: ticks without a start do nothing
        dead_ticks(6, "R10");

        // R4 and R11: timer sweep over preload and tick spacing
        for (int p = 1; p <= 5; p++) begin
            for (int gap = 0; gap <= 2; gap++) begin
                do_start(p, 1'b1, 1'b0, "R4");
                for (int t = 0; t < 3 * p + 1; t++) begin
                    do_tick("R4");
                    for (int g = 0; g < gap; g++) do_idle("R11");
                end
                do_stop("R7");
            end
        end

        // R5 and R2: counter mode one-shot, then stop returns high (R7)
        for (int p = 1; p <= 4; p++) begin
            do_start(p, 1'b0, 1'b0, "R5");
            for (int t = 0; t < p + 3; t++) begin
                do_tick("R5");
                do_idle("R11");
            end
            do_stop("R7");
            dead_ticks(p + 2, "R7");
        end

        // R2: a tick in the start cycle is not counted
        do_start(3, 1'b1, 1'b1, "R2");
        for (int t = 0; t < 4; t++) do_tick("R2");
        do_stop("R2");

        // R8: stop wins over a simultaneous start while idle
        preload = 16'd2;
        mode = 1'b1;
        cyc(1'b0, 1'b1, 1'b1);
        check("R8", "wave", wave_out, 1'b1);
        check("R8", "tc", tc_pulse, 1'b0);
        dead_ticks(5, "R8");
        // R8: simultaneous strobes after a counter-mode expiry
        do_start(2, 1'b0, 1'b0, "R8");
        do_tick("R8");
        do_tick("R8");
        cyc(1'b0, 1'b1, 1'b1);
        check("R8", "wave", wave_out, 1'b1);
        check("R8", "tc", tc_pulse, 1'b0);
        dead_ticks(4, "R8");

        // R9: restart while running
        do_start(4, 1'b1, 1'b0, "R9");
        for (int t = 0; t < 6; t++) do_tick("R9");
        check("R9", "wave low before restart", wave_out, 1'b0);
        do_start(4, 1'b1, 1'b0, "R9");
        for (int t = 0; t < 5; t++) do_tick("R9");
        do_stop("R9");

        // R7: stop in the middle of a count
        do_start(5, 1'b0, 1'b0, "R7");
        for (int t = 0; t < 3; t++) do_tick("R7");
        do_stop("R7");
        dead_ticks(10, "R7");

        // R3: zero preload means 65536 ticks
        do_start(0, 1'b0, 1'b0, "R3");
        for (int t = 0; t < FULL + 1; t++) do_tick("R3");
        do_stop("R3");

        // R6: counter keeps wrapping after expiry, output stays low
        do_start(2, 1'b0, 1'b0, "R6");
        for (int t = 0; t < FULL + 3; t++) do_tick("R6");
        do_stop("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule